// File: doc/BRIEF.md
# Load/Store Data Sizing Unit

This block connects a 64-bit integer datapath to a small byte-addressable data store. It adds a signed 9-bit displacement to a base register value to form the effective address. It reads or writes either a whole aligned doubleword or a single byte. Byte reads come back zero-extended. Byte writes are steered to one lane through an 8-bit lane-enable vector, so the other seven bytes of the stored doubleword keep their values.

A separate combinational detector drives the stall signal that a five-stage pipeline needs. A load that is one stage ahead cannot forward its result to the instruction right behind it. When that instruction reads the load's destination register, the detector raises the stall.

The store itself is a register array of `MEM_WORDS` doublewords held inside the top module. Writes are synchronous. Reads are combinational from the current effective address.

Top module: `lsu_sizing_unit`

## Requirements
- R1: `eff_addr` equals `base_addr` plus `offset`, where `offset` is read as a two's-complement value from -256 to +255 and the sum wraps modulo 2^64.
- R2: When `op_load` is high and `byte_sz` is low, `load_data` is the whole doubleword selected by `eff_addr[3+:log2(MEM_WORDS)]`. Address bits [2:0] are ignored for this size. When `op_load` is low, `load_data` is zero.
- R3: When `op_load` and `byte_sz` are both high, `load_data[7:0]` is byte lane `eff_addr[2:0]` of the selected doubleword and `load_data[63:8]` is zero. Lanes are little-endian: lane k holds bits [8k+7:8k].
- R4: A byte store (`op_store` and `byte_sz` high) has these effects:
  - `byte_we` is one-hot, with bit `eff_addr[2:0]` set.
  - At the next rising clock edge, `store_src[7:0]` is written into that lane.
  - All other lanes of the doubleword stay unchanged.
- R5: A doubleword store (`op_store` high, `byte_sz` low) drives `byte_we` to 8'hFF. At the next rising edge it writes all 64 bits of `store_src`.
- R6: While `op_store` is low, `byte_we` is 8'h00 and no doubleword changes.
- R7: `load_use_stall` is high exactly when all three of these hold:
  - `ex_is_load` is high.
  - `ex_dest` is not 31.
  - `ex_dest` equals `id_src_a` or `id_src_b`.
- R8: While `rst_n` is low, every doubleword is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_load | input | 1 | Load request this cycle |
| op_store | input | 1 | Store request this cycle |
| byte_sz | input | 1 | 1 = byte access, 0 = doubleword access |
| base_addr | input | 64 | Base register value |
| offset | input | 9 | Signed displacement |
| store_src | input | 64 | Store source register value |
| eff_addr | output | 64 | Computed effective address |
| byte_we | output | 8 | Per-lane write enables |
| load_data | output | 64 | Sized and zero-extended load result |
| ex_is_load | input | 1 | The instruction one stage ahead is a load |
| ex_dest | input | 5 | Destination register of that load |
| id_src_a | input | 5 | First source register of the current instruction |
| id_src_b | input | 5 | Second source register of the current instruction |
| load_use_stall | output | 1 | Load-use hazard indication |

## Verification
The assertions assume three things about the inputs:
- `op_load` and `op_store` are never high in the same cycle.
- A doubleword access uses an 8-byte-aligned effective address.
- Reset is held for at least one rising edge before any store.

The stimulus keeps to these rules. The table and the directed tests issue exactly one operation per step, with either both strobes low or one of them high. Every doubleword access in the bench uses a base and displacement whose sum is a multiple of eight. The bench holds reset low for several cycles before the first vector, and again before the final check of the cleared memory.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    localparam int DATA_W = 64;
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    typedef enum logic {
        SZ_DWORD = 1'b0,
        SZ_BYTE  = 1'b1
    } acc_size_e;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
    parameter int ADDR_W = 64,
    parameter int OFF_W  = 9
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] eff_addr
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] disp_ext;

    always_comb begin
        disp_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
        eff_addr = base_addr + disp_ext;
    end
endmodule

// File: rtl/lsu_lane_ctrl.sv
module lsu_lane_ctrl
    import lsu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 is_store,
    input  logic                 is_load,
    input  acc_size_e            acc_size,
    input  logic [LANE_W-1:0]    lane,
    input  logic [DATA_W-1:0]    store_src,
    input  logic [DATA_W-1:0]    mem_word,
    output logic [LANES-1:0]     byte_we,
    output logic [DATA_W-1:0]    wr_word,
    output logic [DATA_W-1:0]    load_data
);
    logic [7:0] lane_bytes [LANES];

    // Split the stored doubleword into lanes and build the write data per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bytes[g] = mem_word[g*8 +: 8];
        assign wr_word[g*8 +: 8] = (acc_size == SZ_BYTE) ? store_src[7:0]
                                                         : store_src[g*8 +: 8];
    end

    always_comb begin
        byte_we = '0;
        if (is_store) begin
            unique case (acc_size)
                SZ_BYTE:  byte_we[lane] = 1'b1;
                SZ_DWORD: byte_we = '1;
            endcase
        end
    end

    always_comb begin
        load_data = '0;
        if (is_load) begin
            unique case (acc_size)
                SZ_BYTE:  load_data[7:0] = lane_bytes[lane];
                SZ_DWORD: load_data = mem_word;
            endcase
        end
    end

    assert_byte_we_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_store && acc_size == SZ_BYTE) |-> ($onehot(byte_we) && byte_we[lane]));

    assert_no_we_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !is_store |-> (byte_we == '0));

    assert_byte_load_zext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_load && acc_size == SZ_BYTE) |-> (load_data[DATA_W-1:8] == '0));
endmodule

// File: rtl/lsu_hazard_detect.sv
module lsu_hazard_detect #(
    parameter int REG_W    = 5,
    parameter int ZERO_REG = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ex_is_load,
    input  logic [REG_W-1:0] ex_dest,
    input  logic [REG_W-1:0] id_src_a,
    input  logic [REG_W-1:0] id_src_b,
    output logic             load_use_stall
);
    logic dest_live;
    logic src_hit;

    always_comb begin
        dest_live      = ex_is_load && (ex_dest != REG_W'(ZERO_REG));
        src_hit        = (ex_dest == id_src_a) || (ex_dest == id_src_b);
        load_use_stall = dest_live && src_hit;
    end

    assert_zero_reg_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dest == REG_W'(ZERO_REG)) |-> !load_use_stall);

    assert_needs_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_is_load |-> !load_use_stall);
endmodule

// File: rtl/lsu_sizing_unit.sv
module lsu_sizing_unit
    import lsu_pkg::*;
#(
    parameter int MEM_WORDS = 16,
    parameter int OFF_W     = 9,
    parameter int REG_W     = 5,
    parameter int ZERO_REG  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_load,
    input  logic              op_store,
    input  logic              byte_sz,
    input  logic [63:0]       base_addr,
    input  logic [OFF_W-1:0]  offset,
    input  logic [63:0]       store_src,
    output logic [63:0]       eff_addr,
    output logic [7:0]        byte_we,
    output logic [63:0]       load_data,
    input  logic              ex_is_load,
    input  logic [REG_W-1:0]  ex_dest,
    input  logic [REG_W-1:0]  id_src_a,
    input  logic [REG_W-1:0]  id_src_b,
    output logic              load_use_stall
);
    localparam int IDX_W = $clog2(MEM_WORDS);

    logic [DATA_W-1:0] mem_q [MEM_WORDS];
    logic [IDX_W-1:0]  widx;
    logic [LANE_W-1:0] lane;
    logic [DATA_W-1:0] wr_word;
    logic [DATA_W-1:0] we_bits;
    acc_size_e         acc_size;

    assign acc_size = byte_sz ? SZ_BYTE : SZ_DWORD;
    assign widx     = eff_addr[LANE_W +: IDX_W];
    assign lane     = eff_addr[LANE_W-1:0];

    lsu_addr_gen #(.ADDR_W(DATA_W), .OFF_W(OFF_W)) u_addr (
        .base_addr (base_addr),
        .offset    (offset),
        .eff_addr  (eff_addr)
    );

    lsu_lane_ctrl u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_store  (op_store),
        .is_load   (op_load),
        .acc_size  (acc_size),
        .lane      (lane),
        .store_src (store_src),
        .mem_word  (mem_q[widx]),
        .byte_we   (byte_we),
        .wr_word   (wr_word),
        .load_data (load_data)
    );

    lsu_hazard_detect #(.REG_W(REG_W), .ZERO_REG(ZERO_REG)) u_hazard (
        .clk            (clk),
        .rst_n          (rst_n),
        .ex_is_load     (ex_is_load),
        .ex_dest        (ex_dest),
        .id_src_a       (id_src_a),
        .id_src_b       (id_src_b),
        .load_use_stall (load_use_stall)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < MEM_WORDS; w++) mem_q[w] <= '0;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (byte_we[l]) mem_q[widx][l*8 +: 8] <= wr_word[l*8 +: 8];
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign we_bits[g*8 +: 8] = {8{byte_we[g]}};
    end

    assert_lanes_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_store |=> (((mem_q[$past(widx)] ^ $past(mem_q[widx])) & ~$past(we_bits)) == '0));

    assert_dword_written_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_store && !byte_sz) |=> (mem_q[$past(widx)] == $past(store_src)));

    assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !op_store |=> (mem_q[$past(widx)] == $past(mem_q[widx])));
endmodule

// File: tb/lsu_sizing_unit_test.sv
module lsu_sizing_unit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_load, op_store, byte_sz;
    logic [63:0] base_addr;
    logic [8:0]  offset;
    logic [63:0] store_src;
    logic [63:0] eff_addr;
    logic [7:0]  byte_we;
    logic [63:0] load_data;
    logic        ex_is_load;
    logic [4:0]  ex_dest, id_src_a, id_src_b;
    logic        load_use_stall;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lsu_sizing_unit uut (
        .clk(clk), .rst_n(rst_n), .op_load(op_load), .op_store(op_store),
        .byte_sz(byte_sz), .base_addr(base_addr), .offset(offset),
        .store_src(store_src), .eff_addr(eff_addr), .byte_we(byte_we),
        .load_data(load_data), .ex_is_load(ex_is_load), .ex_dest(ex_dest),
        .id_src_a(id_src_a), .id_src_b(id_src_b), .load_use_stall(load_use_stall)
    );

    typedef struct packed {
        logic        ld;
        logic        st;
        logic        bsz;
        logic [63:0] base;
        logic [8:0]  off;
        logic [63:0] src;
        logic [63:0] exp_ld;
        logic [7:0]  exp_we;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b1, 1'b0, 64'h100, 9'h000, 64'h1122334455667788, 64'h0, 8'hFF},
        '{1'b1, 1'b0, 1'b0, 64'h108, 9'h1F8, 64'h0, 64'h1122334455667788, 8'h00},
        '{1'b1, 1'b0, 1'b1, 64'h100, 9'h003, 64'h0, 64'h55, 8'h00},
        '{1'b0, 1'b1, 1'b1, 64'h100, 9'h005, 64'hFFFFFFFFFFFFFFAB, 64'h0, 8'h20},
        '{1'b1, 1'b0, 1'b0, 64'h100, 9'h000, 64'h0, 64'h1122AB4455667788, 8'h00},
        '{1'b1, 1'b0, 1'b1, 64'h110, 9'h1F5, 64'h0, 64'hAB, 8'h00},
        '{1'b0, 1'b1, 1'b0, 64'h018, 9'h000, 64'hDEADBEEFCAFEF00D, 64'h0, 8'hFF},
        '{1'b1, 1'b0, 1'b1, 64'h018, 9'h007, 64'h0, 64'hDE, 8'h00},
        '{1'b1, 1'b0, 1'b1, 64'h018, 9'h000, 64'h0, 64'h0D, 8'h00}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic ld, input logic st, input logic bsz,
                         input logic [63:0] b, input logic [8:0] o, input logic [63:0] s);
        op_load = ld; op_store = st; byte_sz = bsz;
        base_addr = b; offset = o; store_src = s;
        #2;
    endtask

    task automatic finish_step();
        @(posedge clk);
        @(negedge clk);
        op_load = 1'b0; op_store = 1'b0;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] model;
        rst_n = 1'b0; op_load = 0; op_store = 0; byte_sz = 0;
        base_addr = 0; offset = 0; store_src = 0;
        ex_is_load = 0; ex_dest = 0; id_src_a = 0; id_src_b = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: memory cleared after reset
        drive(1, 0, 0, 64'h100, 9'h0, 64'h0);
        check("R8 reset word", load_data, 64'h0);
        finish_step();

        // Table walk: R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].ld, TBL[i].st, TBL[i].bsz, TBL[i].base, TBL[i].off, TBL[i].src);
            if (TBL[i].st) check("R4/R5 byte_we", {56'h0, byte_we}, {56'h0, TBL[i].exp_we});
            if (TBL[i].ld) check("R2/R3 load_data", load_data, TBL[i].exp_ld);
            finish_step();
        end

        // R1: displacement extremes and wrap
        drive(0, 0, 0, 64'h0, 9'h0FF, 64'h0);
        check("R1 max positive", eff_addr, 64'hFF);
        drive(0, 0, 0, 64'h200, 9'h100, 64'h0);
        check("R1 most negative", eff_addr, 64'h100);
        drive(0, 0, 0, 64'h4, 9'h1F8, 64'h0);
        check("R1 wrap", eff_addr, 64'hFFFFFFFFFFFFFFFC);
        // R2: no load gives zero data
        check("R2 idle load_data", load_data, 64'h0);

        // R4: walk all lanes of word 2, model tracks untouched lanes
        model = 64'h0;
        for (int l = 0; l < 8; l++) begin
            drive(0, 1, 1, 64'h10, 9'(l), 64'h5A00 + 64'(8'hA0 + l));
            check("R4 one-hot lane", {56'h0, byte_we}, {56'h0, 8'(1 << l)});
            finish_step();
            model[l*8 +: 8] = 8'hA0 + 8'(l);
            drive(1, 0, 0, 64'h10, 9'h0, 64'h0);
            check("R4 lanes preserved", load_data, model);
            finish_step();
        end
        for (int l = 0; l < 8; l++) begin
            drive(1, 0, 1, 64'h17, 9'(-7 + l), 64'h0);
            check("R3 lane readback", load_data, {56'h0, 8'hA0 + 8'(l)});
        end

        // R6: idle cycle with store data present changes nothing
        drive(0, 0, 1, 64'h10, 9'h3, 64'hFFFFFFFFFFFFFFFF);
        check("R6 idle we", {56'h0, byte_we}, 64'h0);
        finish_step();
        drive(1, 0, 0, 64'h10, 9'h0, 64'h0);
        check("R6 memory unchanged", load_data, model);
        check("R6 load we", {56'h0, byte_we}, 64'h0);
        finish_step();

        // R7: load-use detection
        ex_is_load = 1; ex_dest = 5; id_src_a = 5; id_src_b = 7; #1;
        check("R7 match a", {63'h0, load_use_stall}, 64'h1);
        ex_dest = 7; #1;
        check("R7 match b", {63'h0, load_use_stall}, 64'h1);
        ex_dest = 31; id_src_a = 31; id_src_b = 31; #1;
        check("R7 zero reg", {63'h0, load_use_stall}, 64'h0);
        ex_is_load = 0; ex_dest = 5; id_src_a = 5; #1;
        check("R7 not load", {63'h0, load_use_stall}, 64'h0);
        ex_is_load = 1; ex_dest = 4; id_src_a = 5; id_src_b = 6; #1;
        check("R7 no match", {63'h0, load_use_stall}, 64'h0);
        ex_is_load = 0;

        // R8: reset again clears stored data
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        drive(1, 0, 0, 64'h10, 9'h0, 64'h0);
        check("R8 cleared word2", load_data, 64'h0);
        drive(1, 0, 0, 64'h18, 9'h0, 64'h0);
        check("R8 cleared word3", load_data, 64'h0);
        finish_step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule